// File: doc/BRIEF.md
# Two-Client Four-Phase Mutual-Exclusion Arbiter

This block hands one shared resource to one of two requesters. Each requester runs a return-to-zero handshake. It raises its request and waits for its acknowledge. It then lowers the request and waits until the acknowledge drops. The two acknowledges are never high in the same cycle. A grant lasts for the whole handshake. It is not re-arbitrated every cycle.

The request inputs may change at any time relative to the clock. Each one passes through a cascade of synchronizer flip-flops before the grant logic sees it. Every extra stage adds one clock period of settling time: latency goes up and the chance of a synchronization failure goes down. The acknowledges come straight from flip-flops, so they cannot glitch. If both requests show up in the same cycle, the tie goes to the requester that did not win the previous grant. A requester that drops its request before it is acknowledged sets a sticky protocol-error flag.

Top module: `mutex_arbiter2`

## Requirements
- R1: `ack_o[0]` and `ack_o[1]` are never both 1 in the same cycle.
- R2: A request passes through SYNC_STAGES flip-flops (default 2, minimum 2). A request that rises while the arbiter is idle has its acknowledge rise on clock edge SYNC_STAGES+1 after the change, and not earlier.
- R3: A granted acknowledge stays 1 for as long as that client's request stays 1.
- R4: When the granted client lowers its request, its acknowledge falls on edge SYNC_STAGES+1 after the change. The other acknowledge is still 0 right after that edge.
- R5: Requests first seen in the same cycle go to the client that did not win the previous grant. After reset, client 0 wins such a tie.
- R6: A request that arrives while the other client holds the grant waits. It is acknowledged on the edge after the holder's acknowledge falls.
- R7: A client whose synchronized request falls before its acknowledge sets `proto_err_o` to 1 on the next edge. The flag stays 1 until reset. That client receives no acknowledge for the abandoned request.
- R8: An acknowledge rises only for a client whose request is high.
- R9: Asserting `rst_n` low clears the synchronizer stages, both acknowledges, the tie history and `proto_err_o`.
- R10: Every request that follows the handshake is eventually acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release it away from the clock edge |
| req_i | input | 2 | Asynchronous requests; bit k belongs to client k |
| ack_o | output | 2 | Registered acknowledges; bit k belongs to client k |
| proto_err_o | output | 1 | Sticky flag: a request was withdrawn before it was acknowledged |

## Verification
The assertions check four things on every cycle, measured against the synchronized requests:
- the two acknowledges are mutually exclusive;
- an acknowledge never rises without a request;
- an acknowledge is held while its request is high, and both acknowledges are low on the edge after a release;
- the error flag stays set once set.

Other behaviour needs whole scenarios, which only the bench can run:
- the end-to-end latency through the synchronizer;
- the tie-break history and its reset;
- the hand-over to a waiting client;
- the error flag after an abandoned request;
- the liveness of randomly overlapping handshakes.

// File: rtl/mutex_pkg.sv
package mutex_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_GNT0 = 2'd1,
    ST_GNT1 = 2'd2
  } arb_state_e;

  // Winner choice from the idle state.
  // req  : synchronized requests this cycle
  // prev : synchronized requests one cycle earlier
  // last : previous winner
  // Returns the client index.
  function automatic logic pick_winner(input logic [1:0] req,
                                       input logic [1:0] prev,
                                       input logic       last);
    logic [1:0] older;
    older = req & prev;
    if (!(req[0] && req[1])) begin
      pick_winner = req[1];
    end else if (older == 2'b01) begin
      pick_winner = 1'b0;
    end else if (older == 2'b10) begin
      pick_winner = 1'b1;
    end else begin
      pick_winner = ~last;
    end
  endfunction

endpackage

// File: rtl/mutex_sync_chain.sv
module mutex_sync_chain #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  generate
    if (STAGES < 2) begin : g_bad_depth
      $error("mutex_sync_chain: STAGES must be at least 2");
    end
  endgenerate

  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q <= {stg_q[STAGES-2:0], d_i};
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/mutex_grant_fsm.sv
module mutex_grant_fsm
  import mutex_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sreq_i,
  output logic [1:0] ack_o
);

  arb_state_e st_q, st_nxt;
  logic [1:0] prev_q;
  logic       last_q;
  logic       win;
  logic       grant_fire;
  logic [1:0] ack_nxt;

  // Next-state process
  always_comb begin
    st_nxt     = st_q;
    grant_fire = 1'b0;
    win        = pick_winner(sreq_i, prev_q, last_q);
    case (st_q)
      ST_IDLE: begin
        if (|sreq_i) begin
          grant_fire = 1'b1;
          st_nxt     = win ? ST_GNT1 : ST_GNT0;
        end
      end
      ST_GNT0: if (!sreq_i[0]) st_nxt = ST_IDLE;
      ST_GNT1: if (!sreq_i[1]) st_nxt = ST_IDLE;
      default: st_nxt = ST_IDLE;
    endcase
    ack_nxt = {st_nxt == ST_GNT1, st_nxt == ST_GNT0};
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      prev_q <= '0;
      ack_o  <= '0;
      last_q <= 1'b1;
    end else begin
      st_q   <= st_nxt;
      prev_q <= sreq_i;
      ack_o  <= ack_nxt;
      if (grant_fire) begin
        last_q <= win;
      end
    end
  end

endmodule

// File: rtl/mutex_proto_err.sv
module mutex_proto_err (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sreq_i,
  input  logic [1:0] ack_i,
  output logic       err_o
);

  logic [1:0] prev_q;
  logic       withdrawn;

  assign withdrawn = |(prev_q & ~sreq_i & ~ack_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      err_o  <= 1'b0;
    end else begin
      prev_q <= sreq_i;
      if (withdrawn) begin
        err_o <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/mutex_arbiter2.sv
module mutex_arbiter2 #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] req_i,
  output logic [1:0] ack_o,
  output logic       proto_err_o
);

  localparam int NCLIENT = 2;

  logic [NCLIENT-1:0] req_sync;

  mutex_sync_chain #(
    .STAGES(SYNC_STAGES),
    .WIDTH (NCLIENT)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (req_i),
    .q_o  (req_sync)
  );

  mutex_grant_fsm u_fsm (
    .clk   (clk),
    .rst_n (rst_n),
    .sreq_i(req_sync),
    .ack_o (ack_o)
  );

  mutex_proto_err u_err (
    .clk   (clk),
    .rst_n (rst_n),
    .sreq_i(req_sync),
    .ack_i (ack_o),
    .err_o (proto_err_o)
  );

endmodule

// File: rtl/mutex_arbiter2_sva.sv
module mutex_arbiter2_sva (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] sreq,
  input logic [1:0] ack,
  input logic       err
);

  // R1
  p_mutex_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack[0] && ack[1]));

  // R8
  p_rise_needs_req_r8_c0: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack[0]) |-> $past(sreq[0]));
  p_rise_needs_req_r8_c1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack[1]) |-> $past(sreq[1]));

  // R3
  p_hold_r3_c0: assert property (@(posedge clk) disable iff (!rst_n)
    (ack[0] && sreq[0]) |=> ack[0]);
  p_hold_r3_c1: assert property (@(posedge clk) disable iff (!rst_n)
    (ack[1] && sreq[1]) |=> ack[1]);

  // R4
  p_release_r4_c0: assert property (@(posedge clk) disable iff (!rst_n)
    (ack[0] && !sreq[0]) |=> (ack == 2'b00));
  p_release_r4_c1: assert property (@(posedge clk) disable iff (!rst_n)
    (ack[1] && !sreq[1]) |=> (ack == 2'b00));

  // R7
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

endmodule

bind mutex_arbiter2 mutex_arbiter2_sva u_sva (
  .clk  (clk),
  .rst_n(rst_n),
  .sreq (req_sync),
  .ack  (ack_o),
  .err  (proto_err_o)
);

// File: tb/mutex_arbiter2_test.sv
`timescale 1ns/1ps
module mutex_arbiter2_test;

  localparam int STG = 2;
  localparam int LAT = STG + 1;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       r0_d, r1_d;
  logic [1:0] req;
  logic [1:0] ack;
  logic       err;

  int checks = 0;
  int fails  = 0;
  int tag    = 0;
  int q0[$];
  int q1[$];
  logic [1:0] ack_prev;

  assign req = {r1_d, r0_d};

  always #10 clk = ~clk;

  mutex_arbiter2 #(.SYNC_STAGES(STG)) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req),
    .ack_o      (ack),
    .proto_err_o(err)
  );

  task automatic check(input bit ok, input string rq, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  // Sample point: 5 ns after the n-th following rising edge
  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  // Driver: raise a set of requests at a falling edge and push expectations
  task automatic raise(input logic [1:0] m, input logic [1:0] expect_grant);
    @(negedge clk);
    if (m[0]) r0_d = 1'b1;
    if (m[1]) r1_d = 1'b1;
    if (expect_grant[0]) q0.push_back(tag++);
    if (expect_grant[1]) q1.push_back(tag++);
  endtask

  task automatic drop(input logic [1:0] m);
    @(negedge clk);
    if (m[0]) r0_d = 1'b0;
    if (m[1]) r1_d = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    r0_d  = 1'b0;
    r1_d  = 1'b0;
    rst_n = 1'b0;
    q0.delete();
    q1.delete();
    #5;
    check(ack == 2'b00, "R9", "ack during reset", ack, 0);
    check(err == 1'b0, "R9", "err during reset", err, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Monitor / scoreboard
  always @(posedge clk) begin
    #5;
    if (!rst_n) begin
      ack_prev = 2'b00;
    end else begin
      check(!(ack[0] && ack[1]), "R1", "both acks high", ack, 0);
      if (ack[0] && !ack_prev[0]) begin
        check(q0.size() > 0, "R8", "unexpected ack0 rise", q0.size(), 1);
        check(req[0] == 1'b1, "R8", "ack0 rose with req0 low", req[0], 1);
        if (q0.size() > 0) void'(q0.pop_front());
      end
      if (ack[1] && !ack_prev[1]) begin
        check(q1.size() > 0, "R8", "unexpected ack1 rise", q1.size(), 1);
        check(req[1] == 1'b1, "R8", "ack1 rose with req1 low", req[1], 1);
        if (q1.size() > 0) void'(q1.pop_front());
      end
      ack_prev = ack;
    end
  end

  // Client process for random four-phase traffic
  task automatic run_client(input int k, input int n);
    for (int i = 0; i < n; i++) begin
      repeat ($urandom_range(0, 6)) @(negedge clk);
      raise(k == 0 ? 2'b01 : 2'b10, k == 0 ? 2'b01 : 2'b10);
      edges(1);
      while (ack[k] !== 1'b1) edges(1);
      repeat ($urandom_range(0, 4)) @(negedge clk);
      drop(k == 0 ? 2'b01 : 2'b10);
      edges(1);
      while (ack[k] !== 1'b0) edges(1);
    end
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R10 watchdog expired actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    r0_d  = 1'b0;
    r1_d  = 1'b0;
    ack_prev = 2'b00;
    void'($urandom(7));
    do_reset();

    // R9 reset state
    edges(1);
    check(ack == 2'b00, "R9", "ack after reset", ack, 0);
    check(err == 1'b0, "R9", "err after reset", err, 0);

    // R5 tie after reset, R2 latency, R3 hold, R4 release, R6 hand-over
    raise(2'b11, 2'b11);
    edges(STG);
    check(ack == 2'b00, "R2", "ack before latency", ack, 0);
    edges(1);
    check(ack == 2'b01, "R5", "tie after reset to client 0", ack, 1);
    edges(5);
    check(ack == 2'b01, "R3", "grant held", ack, 1);
    drop(2'b01);
    edges(STG);
    check(ack == 2'b01, "R4", "ack kept until sync", ack, 1);
    edges(1);
    check(ack == 2'b00, "R4", "release gap", ack, 0);
    edges(1);
    check(ack == 2'b10, "R6", "waiting client granted", ack, 2);
    drop(2'b10);
    edges(LAT);
    check(ack == 2'b00, "R4", "client 1 released", ack, 0);

    // R5 history: client 0 wins alone, then a tie goes to client 1
    raise(2'b01, 2'b01);
    edges(LAT);
    check(ack == 2'b01, "R2", "single request latency", ack, 1);
    drop(2'b01);
    edges(LAT);
    check(ack == 2'b00, "R4", "single release", ack, 0);
    raise(2'b11, 2'b11);
    edges(LAT);
    check(ack == 2'b10, "R5", "tie to previous loser", ack, 2);
    drop(2'b10);
    edges(LAT + 1);
    check(ack == 2'b01, "R6", "client 0 after hand-over", ack, 1);
    drop(2'b01);
    edges(LAT);
    check(ack == 2'b00, "R4", "all released", ack, 0);

    // R7 abandoned request
    raise(2'b01, 2'b01);
    edges(LAT);
    check(ack == 2'b01, "R7", "holder granted", ack, 1);
    raise(2'b10, 2'b00);
    edges(3);
    drop(2'b10);
    edges(LAT);
    check(err == 1'b1, "R7", "error flag set", err, 1);
    check(ack == 2'b01, "R7", "holder unaffected", ack, 1);
    drop(2'b01);
    edges(LAT + 5);
    check(ack == 2'b00, "R7", "no grant to abandoned client", ack, 0);
    check(err == 1'b1, "R7", "error flag sticky", err, 1);
    raise(2'b01, 2'b01);
    edges(LAT);
    check(ack == 2'b01, "R7", "new grant after error", ack, 1);
    check(err == 1'b1, "R7", "error still sticky", err, 1);
    drop(2'b01);
    edges(LAT);

    // R9 reset clears error and tie history (last winner was 0)
    do_reset();
    edges(1);
    check(err == 1'b0, "R9", "err cleared", err, 0);
    raise(2'b11, 2'b11);
    edges(LAT);
    check(ack == 2'b01, "R9", "tie history cleared", ack, 1);
    drop(2'b01);
    edges(LAT + 1);
    check(ack == 2'b10, "R6", "waiting client after reset", ack, 2);
    drop(2'b10);
    edges(LAT);

    // R10 random overlapping traffic
    fork
      run_client(0, 40);
      run_client(1, 40);
    join
    edges(LAT + 2);
    check(q0.size() == 0, "R10", "client 0 pending grants", q0.size(), 0);
    check(q1.size() == 0, "R10", "client 1 pending grants", q1.size(), 0);
    check(err == 1'b0, "R7", "no false error", err, 0);
    check(ack == 2'b00, "R4", "idle at end", ack, 0);

    summary();
    $finish;
  end

endmodule